// File: doc/BRIEF.md
# Fixed-Off-Time Winding Current Chopper

This block regulates the current in one winding of a bipolar stepper motor. It drives the four switches of one H-bridge: a high-side and a low-side switch on each of the two legs. The winding direction follows a direction input. The low-side switch that carries the return current is chopped so that the winding current stays near a nominal level. An external current comparator reports whether the actual current is above the nominal current. When it is, a regulation flop clears and the low-side switch opens. The high-side switch on the other leg stays closed for the whole direction interval, so the current freewheels while the low side is open.

The low-side switch is closed again by one of two mechanisms. In timer mode, a digital timer replaces an analog RC element. Each charge interval runs its full length, even when the comparator trips early. A discharge (off) interval follows, and the low side closes again when the discharge interval ends. In sync mode, the timer is not used: a falling edge on an external sync line closes the low side, but only while the current is below nominal. A direction change forces all four switches open for a fixed deadtime before the new pair is closed. A low enable input keeps all four switches open.

Top module: `chop_pwm_ctrl`

## Requirements
- R1: While the enable input is low, all four gate outputs are 0. An enable change reaches the gates two clock edges after it is applied. While the block is disabled, the regulation flop is cleared and the timer returns to the start of a charge interval.
- R2: When the bridge is active and the direction input is 0, the leg-2 high side is on and the leg-1 low side is the chopped switch. When the direction input is 1, the leg-1 high side is on and the leg-2 low side is chopped. The active high side stays on continuously while the direction is steady.
- R3: The high-side and low-side gates of the same leg are never on together.
- R4: When the comparator input is 1 (current above nominal), the regulation flop clears. The low-side gate turns off at the third clock edge after the comparator input rises.
- R5: In timer mode, with the comparator input low, the low-side gate first turns on exactly CHG_CYC + DIS_CYC cycles after the high-side gate turns on.
- R6: In timer mode, each off interval of the low side lasts exactly max(DIS_CYC, CHG_CYC + DIS_CYC − T_on) cycles, where T_on is the length of the preceding on interval. The charge interval therefore always completes before the discharge interval starts.
- R7: In sync mode, the timer never closes the low side. A falling edge on the sync input, with the comparator input low, turns the low side on at the third clock edge after the edge is applied.
- R8: In sync mode, a sync falling edge that arrives while the synchronized comparator is 1 is ignored and is not remembered. This includes an edge that reaches the flop in the same cycle as a clear.
- R9: After a change of the direction input while the bridge is active, all four gates are off for exactly DT_CYC cycles. The new pair then turns on.
- R10: While synchronous reset is held, all four gates are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_in | input | 1 | Bridge enable (asynchronous, synchronized internally) |
| phase_in | input | 1 | Current direction select (asynchronous) |
| sync_mode | input | 1 | 0 = internal off-time timer, 1 = external sync edges (quasi-static) |
| sync_in | input | 1 | External sync line; a falling edge requests the low side to close |
| over_nom_in | input | 1 | Comparator result, 1 when actual current exceeds nominal |
| gate_hi_q1 | output | 1 | Leg-1 high-side gate |
| gate_hi_q2 | output | 1 | Leg-2 high-side gate |
| gate_lo_q1 | output | 1 | Leg-1 low-side gate (chopped) |
| gate_lo_q2 | output | 1 | Leg-2 low-side gate (chopped) |

## Verification
Two events can coincide on the regulation flop: a set request (a sync falling edge, or the end of a discharge interval) and a clear from the comparator. The bench provokes this in sync mode by driving the comparator high and the sync line low at the same clock edge, so that both pass through their synchronizers together. It then requires the low side to stay off, and to remain off after the comparator drops, because the edge is not held. In timer mode, the random coil model makes the comparator trip both before and after the charge interval ends. Every off interval is then judged against the max() rule of R6.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

    // bit positions inside the synchronizer vector
    localparam int SYN_EN  = 0;
    localparam int SYN_PH  = 1;
    localparam int SYN_SY  = 2;
    localparam int SYN_CMP = 3;
    localparam int SYN_W   = 4;

    typedef enum logic [1:0] {
        TM_CHARGE = 2'd0,   // charge interval counting
        TM_FULL   = 2'd1,   // charge complete, waiting for a trip
        TM_DISCH  = 2'd2    // off interval counting
    } tmr_state_e;

    typedef struct packed {
        logic hi_q1;
        logic hi_q2;
        logic lo_q1;
        logic lo_q2;
    } gate_t;

    localparam gate_t GATES_OFF = '0;

    // map direction and flop state onto the four switches
    function automatic gate_t steer_gates(input logic live, input logic dir,
                                          input logic sink_on);
        gate_t g;
        g = GATES_OFF;
        if (live) begin
            if (dir) begin
                g.hi_q1 = 1'b1;
                g.lo_q2 = sink_on;
            end else begin
                g.hi_q2 = 1'b1;
                g.lo_q1 = sink_on;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/chop_sync.sv
`timescale 1ns/1ps
module chop_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
`timescale 1ns/1ps
module chop_timer
    import chop_pkg::*;
#(
    parameter int CHG_CYC = 400,
    parameter int DIS_CYC = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,        // timer mode and bridge enabled
    input  logic tripped,    // flop clear or clearing this cycle
    output logic set_pulse   // end of off interval
);
    localparam int MAXC = (CHG_CYC > DIS_CYC) ? CHG_CYC : DIS_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] CHG_LAST = CW'(CHG_CYC - 1);
    localparam logic [CW-1:0] DIS_LAST = CW'(DIS_CYC - 1);

    tmr_state_e      state;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= TM_CHARGE;
            cnt   <= '0;
        end else begin
            unique case (state)
                TM_CHARGE: begin
                    if (cnt == CHG_LAST) begin
                        cnt   <= '0;
                        state <= tripped ? TM_DISCH : TM_FULL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TM_FULL: begin
                    if (tripped) begin
                        state <= TM_DISCH;
                        cnt   <= '0;
                    end
                end
                TM_DISCH: begin
                    if (cnt == DIS_LAST) begin
                        cnt   <= '0;
                        state <= TM_CHARGE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= TM_CHARGE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign set_pulse = run && (state == TM_DISCH) && (cnt == DIS_LAST);
endmodule

// File: rtl/chop_steer.sv
`timescale 1ns/1ps
module chop_steer
    import chop_pkg::*;
#(
    parameter int DT_CYC = 1250
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_s,
    input  logic  phase_s,
    input  logic  sink_on,
    output gate_t gates,
    output logic  side_o
);
    localparam int DW = $clog2(DT_CYC + 1);
    localparam logic [DW-1:0] DT_LOAD = DW'(DT_CYC - 1);

    logic          side;
    logic [DW-1:0] dt_cnt;
    logic          live;

    always_ff @(posedge clk) begin
        if (rst) begin
            side   <= 1'b0;
            dt_cnt <= '0;
        end else if (!en_s) begin
            side   <= phase_s;
            dt_cnt <= '0;
        end else if (phase_s != side) begin
            side   <= phase_s;
            dt_cnt <= DT_LOAD;
        end else if (dt_cnt != '0) begin
            dt_cnt <= dt_cnt - 1'b1;
        end
    end

    assign live   = en_s && (phase_s == side) && (dt_cnt == '0);
    assign gates  = steer_gates(live, side, sink_on);
    assign side_o = side;
endmodule

// File: rtl/chop_pwm_ctrl.sv
`timescale 1ns/1ps
module chop_pwm_ctrl
    import chop_pkg::*;
#(
    parameter int CHG_CYC = 400,
    parameter int DIS_CYC = 1200,
    parameter int DT_CYC  = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_in,
    input  logic phase_in,
    input  logic sync_mode,
    input  logic sync_in,
    input  logic over_nom_in,
    output logic gate_hi_q1,
    output logic gate_hi_q2,
    output logic gate_lo_q1,
    output logic gate_lo_q2
);
    logic [SYN_W-1:0] raw_vec;
    logic [SYN_W-1:0] syn_vec;
    logic en_s, ph_s, sy_s, cmp_s;
    logic sy_prev, sync_fall;
    logic tmr_set, set_req, reg_on, tripped;
    logic steer_side;
    gate_t gates;

    assign raw_vec[SYN_EN]  = enable_in;
    assign raw_vec[SYN_PH]  = phase_in;
    assign raw_vec[SYN_SY]  = sync_in;
    assign raw_vec[SYN_CMP] = over_nom_in;

    chop_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_vec), .q(syn_vec)
    );

    assign en_s  = syn_vec[SYN_EN];
    assign ph_s  = syn_vec[SYN_PH];
    assign sy_s  = syn_vec[SYN_SY];
    assign cmp_s = syn_vec[SYN_CMP];

    always_ff @(posedge clk) begin
        if (rst) sy_prev <= 1'b0;
        else     sy_prev <= sy_s;
    end
    assign sync_fall = sy_prev && !sy_s;

    chop_timer #(.CHG_CYC(CHG_CYC), .DIS_CYC(DIS_CYC)) u_timer (
        .clk(clk), .rst(rst),
        .run(en_s && !sync_mode),
        .tripped(tripped),
        .set_pulse(tmr_set)
    );

    assign set_req = sync_mode ? sync_fall : tmr_set;
    assign tripped = !reg_on || cmp_s;

    // regulation flop: clear dominates set
    always_ff @(posedge clk) begin
        if (rst || !en_s)  reg_on <= 1'b0;
        else if (cmp_s)    reg_on <= 1'b0;
        else if (set_req)  reg_on <= 1'b1;
    end

    chop_steer #(.DT_CYC(DT_CYC)) u_steer (
        .clk(clk), .rst(rst), .en_s(en_s), .phase_s(ph_s),
        .sink_on(reg_on), .gates(gates), .side_o(steer_side)
    );

    assign gate_hi_q1 = gates.hi_q1;
    assign gate_hi_q2 = gates.hi_q2;
    assign gate_lo_q1 = gates.lo_q1;
    assign gate_lo_q2 = gates.lo_q2;
endmodule

// File: rtl/chop_pwm_chk.sv
`timescale 1ns/1ps
module chop_pwm_chk (
    input logic clk,
    input logic rst,
    input logic en_s,
    input logic cmp_s,
    input logic side,
    input logic hi_q1,
    input logic hi_q2,
    input logic lo_q1,
    input logic lo_q2
);
    assert_off_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !en_s |-> !(hi_q1 || hi_q2 || lo_q1 || lo_q2));

    assert_one_source_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hi_q1, hi_q2}));

    assert_sink_pair1_R2: assert property (@(posedge clk) disable iff (rst)
        lo_q1 |-> hi_q2);

    assert_sink_pair2_R2: assert property (@(posedge clk) disable iff (rst)
        lo_q2 |-> hi_q1);

    assert_leg_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(hi_q1 && lo_q1) && !(hi_q2 && lo_q2));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        cmp_s |=> !(lo_q1 || lo_q2));

    assert_deadtime_R9: assert property (@(posedge clk) disable iff (rst)
        (side != $past(side)) |-> !(hi_q1 || hi_q2 || lo_q1 || lo_q2));

    assert_reset_off_R10: assert property (@(posedge clk)
        rst |=> !(hi_q1 || hi_q2 || lo_q1 || lo_q2));
endmodule

bind chop_pwm_ctrl chop_pwm_chk u_chk (
    .clk(clk), .rst(rst), .en_s(en_s), .cmp_s(cmp_s), .side(steer_side),
    .hi_q1(gate_hi_q1), .hi_q2(gate_hi_q2), .lo_q1(gate_lo_q1), .lo_q2(gate_lo_q2)
);

// File: tb/chop_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module chop_pwm_ctrl_tb_top;
    localparam int CHG = 12;
    localparam int DIS = 10;
    localparam int DT  = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, en, ph, mode, sync_l, cmp_force, coil_mode, coil_cmp, cmp_in;
    logic hq1, hq2, lq1, lq2;
    assign cmp_in = coil_mode ? coil_cmp : cmp_force;

    chop_pwm_ctrl #(.CHG_CYC(CHG), .DIS_CYC(DIS), .DT_CYC(DT)) dut_i (
        .clk(clk), .rst(rst), .enable_in(en), .phase_in(ph), .sync_mode(mode),
        .sync_in(sync_l), .over_nom_in(cmp_in),
        .gate_hi_q1(hq1), .gate_hi_q2(hq2), .gate_lo_q1(lq1), .gate_lo_q2(lq2)
    );

    int total = 0, bad = 0;
    int leg_bad = 0, leg_cycles = 0, src_bad = 0, src_cycles = 0;
    int coil_i = 0, nom = 10;
    logic meas_on = 1'b0;
    logic prev_snk = 1'b0, snk_now;
    int run_len = 0, last_on = 0;
    bit have_on = 0;
    int n_short = 0, n_long = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_off(input int on_len);
        int a;
        a = CHG + DIS - on_len;
        return (a > DIS) ? a : DIS;
    endfunction

    function automatic int gate_word();
        return int'({hq1, hq2, lq1, lq2});
    endfunction

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // coil model, leg exclusivity, off-interval measurement
    always @(negedge clk) begin
        snk_now = lq1 || lq2;
        if (!rst) begin
            leg_cycles++;
            if ((hq1 && lq1) || (hq2 && lq2)) leg_bad++;
        end
        if (coil_mode) begin
            if (snk_now) coil_i = coil_i + 1;
            else coil_i = (coil_i > 3) ? coil_i - 3 : 0;
            coil_cmp = (coil_i > nom);
        end else begin
            coil_i = 0;
            coil_cmp = 1'b0;
        end
        if (meas_on) begin
            src_cycles++;
            if (ph ? !(hq1 && !hq2) : !(hq2 && !hq1)) src_bad++;
            if (snk_now == prev_snk) begin
                run_len++;
            end else begin
                if (snk_now) begin
                    if (have_on) begin
                        check(run_len == exp_off(last_on), "R6 off interval",
                              run_len, exp_off(last_on));
                        if (last_on < CHG) n_short++; else n_long++;
                    end
                end else begin
                    last_on = run_len;
                    have_on = 1;
                end
                run_len = 1;
                prev_snk = snk_now;
            end
        end else begin
            prev_snk = 1'b0;
            run_len = 0;
            have_on = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int cnt, n, zeros, seed;
        seed = $urandom(1729);
        rst = 1; en = 0; ph = 0; mode = 0; sync_l = 1; cmp_force = 0; coil_mode = 0;
        step(5);
        check(gate_word() == 0, "R10 reset gates", gate_word(), 0);
        rst = 0;
        step(3);
        check(gate_word() == 0, "R1 disabled", gate_word(), 0);
        ph = 1; step(4);
        check(gate_word() == 0, "R1 disabled ph1", gate_word(), 0);
        ph = 0; step(4);

        // activation and first closing of the low side
        en = 1;
        cnt = 0;
        while (!hq2 && cnt < 20) begin step(1); cnt++; end
        check(cnt == 2, "R1 enable latency", cnt, 2);
        n = 0;
        while (!lq1 && n < 200) begin step(1); n++; end
        check(n == CHG + DIS, "R5 first sink delay", n, CHG + DIS);
        check(!hq1 && !lq2, "R2 dir0 pair", gate_word(), 4'b0110);

        // comparator clear latency
        step(3);
        cmp_force = 1;
        step(2);
        check(lq1 == 1'b1, "R4 before clear", lq1, 1);
        step(1);
        check(lq1 == 1'b0, "R4 clear", lq1, 0);
        check(hq2 == 1'b1, "R2 source held", hq2, 1);
        cmp_force = 0;
        step(DIS + 8);
        check(lq1 == 1'b1, "R6 reclose after off", lq1, 1);

        // deadtime both directions
        ph = 1; zeros = 0; cnt = 0;
        while (!hq1 && cnt < 50) begin
            step(1); cnt++;
            if (!hq1 && !hq2 && !lq1 && !lq2) zeros++;
        end
        check(zeros == DT, "R9 deadtime 0->1", zeros, DT);
        check(!lq1 && !hq2, "R2 dir1 pair", gate_word(), 4'b1001);
        ph = 0; zeros = 0; cnt = 0;
        while (!hq2 && cnt < 50) begin
            step(1); cnt++;
            if (!hq1 && !hq2 && !lq1 && !lq2) zeros++;
        end
        check(zeros == DT, "R9 deadtime 1->0", zeros, DT);

        // enable fall
        en = 0;
        step(1);
        check(hq2 == 1'b1, "R1 disable latency early", hq2, 1);
        step(1);
        check(gate_word() == 0, "R1 disable latency", gate_word(), 0);

        // random chopping segments
        for (int s = 0; s < 14; s++) begin
            ph = 1'($urandom % 2);
            nom = 2 + int'($urandom % 30);
            coil_mode = 1;
            step(4);
            en = 1;
            step(3);
            meas_on = 1;
            step(300 + int'($urandom % 200));
            meas_on = 0;
            en = 0;
            coil_mode = 0;
            step(4);
        end
        check(n_short > 0, "R6 trip inside charge seen", n_short, 1);
        check(n_long > 0, "R6 trip after charge seen", n_long, 1);
        check(src_bad == 0, "R2 source steady", src_bad, 0);

        // sync mode
        mode = 1; ph = 0; cmp_force = 0; sync_l = 1;
        step(2);
        en = 1;
        step(CHG + DIS + 10);
        check(!lq1 && !lq2, "R7 no timer close", gate_word(), 4'b0100);
        sync_l = 0;
        step(2);
        check(lq1 == 1'b0, "R7 before close", lq1, 0);
        step(1);
        check(lq1 == 1'b1, "R7 sync close", lq1, 1);
        sync_l = 1;
        step(3);
        cmp_force = 1;
        step(3);
        check(lq1 == 1'b0, "R4 clear sync mode", lq1, 0);
        sync_l = 0;
        step(6);
        check(lq1 == 1'b0, "R8 edge ignored", lq1, 0);
        sync_l = 1;
        step(3);
        cmp_force = 0;
        step(6);
        check(lq1 == 1'b0, "R8 edge not held", lq1, 0);
        cmp_force = 1; sync_l = 0;
        step(6);
        check(lq1 == 1'b0, "R8 same cycle clear wins", lq1, 0);
        sync_l = 1; cmp_force = 0;
        step(4);
        check(lq1 == 1'b0, "R8 still open", lq1, 0);
        sync_l = 0;
        step(3);
        check(lq1 == 1'b1, "R7 second close", lq1, 1);

        en = 0;
        step(4);
        check(leg_bad == 0 && leg_cycles > 0, "R3 leg exclusive", leg_bad, 0);
        done = 1;
        report();
        $finish;
    end
endmodule